// File: doc/BRIEF.md
# DMA Address Generator with Reload

This block produces the source and destination addresses for one DMA channel. Each of the two addresses is held in a working register that a data-movement engine reads. On each access strobe it either stays put, counts up by one, or counts down by one, depending on that address's own direction field. Bus protocol and data transfer belong to the surrounding channel logic.

Writing a start address stores it twice: once as the working address and once as a saved original. Each address also has its own reload policy. The policy picks one of three event pulses (end of burst, end of block, end of transaction), or none. When the chosen event arrives, the working address is restored from the saved original. This lets a channel sweep the same buffer again and again without software reprogramming it.

Top module: `dma_addr_gen`

## Requirements
- R1: While `rst` is high at a clock edge, both `src_addr` and `dst_addr` become 0 and both saved originals become 0.
- R2: A cycle with a lane's load input high sets that lane's working address to its start input at the next edge, and records that value as the lane's saved original.
- R3: With direction field 01 (increment), each cycle with the lane's step strobe high adds 1 to the working address modulo 2^24, so FFFFFF steps to 000000.
- R4: With direction field 10 (decrement), each step strobe subtracts 1 modulo 2^24, so 000000 steps to FFFFFF.
- R5: With direction field 00 (fixed), and also with the unused code 11, a step strobe leaves the working address unchanged.
- R6: A cycle with no load, no selected reload event and no step leaves the working address unchanged.
- R7: Reload field 01 restores the saved original on `burst_end`, 10 restores it on `block_end`, and 11 restores it on `xact_end`. The two event pulses that the field does not select have no effect on that address.
- R8: Reload field 00 (never) makes all three event pulses leave the working address unchanged.
- R9: If a selected reload event and a step strobe arrive in the same cycle, the address takes its saved original and the step is discarded.
- R10: A load in the same cycle as a reload event or a step strobe takes precedence: the address becomes the new start value.
- R11: The source and destination lanes are independent. The load, step, direction and reload inputs of one lane never change the other lane's address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| src_load | input | 1 | Load `src_start` as working and saved source address |
| src_start | input | ADDR_W | Source start address |
| src_dir | input | 2 | Source direction: 00 fixed, 01 increment, 10 decrement, 11 fixed |
| src_rld | input | 2 | Source reload: 00 never, 01 burst, 10 block, 11 transaction |
| src_step | input | 1 | Source access strobe |
| dst_load | input | 1 | Load `dst_start` as working and saved destination address |
| dst_start | input | ADDR_W | Destination start address |
| dst_dir | input | 2 | Destination direction, same encoding as `src_dir` |
| dst_rld | input | 2 | Destination reload, same encoding as `src_rld` |
| dst_step | input | 1 | Destination access strobe |
| burst_end | input | 1 | End-of-burst pulse |
| block_end | input | 1 | End-of-block pulse |
| xact_end | input | 1 | End-of-transaction pulse |
| src_addr | output | ADDR_W | Current source address (registered) |
| dst_addr | output | ADDR_W | Current destination address (registered) |

## Verification
A lane's access strobe and its selected end event can arrive in the same cycle, and a load can also coincide with both. The bench raises the step strobe together with `burst_end` while the reload field selects burst, and then adds a load on top of that. A reference model in the bench applies the priority load, then reload, then step. A scoreboard compares each model prediction with the registered address one cycle later. In the checker, the reload property is written without any condition on the strobe, so a step that wins over a reload breaks it.

// File: rtl/dag_pkg.sv
package dag_pkg;
  typedef enum logic [1:0] {
    DIR_HOLD = 2'b00,
    DIR_UP   = 2'b01,
    DIR_DOWN = 2'b10,
    DIR_RSVD = 2'b11
  } dir_e;

  typedef enum logic [1:0] {
    RLD_NONE  = 2'b00,
    RLD_BURST = 2'b01,
    RLD_BLOCK = 2'b10,
    RLD_XACT  = 2'b11
  } rld_e;

  localparam int NUM_LANES = 2;
endpackage

// File: rtl/dag_reload_sel.sv
module dag_reload_sel
  import dag_pkg::*;
(
  input  logic [1:0] policy,
  input  logic       burst_end,
  input  logic       block_end,
  input  logic       xact_end,
  output logic       fire
);
  always_comb begin
    case (rld_e'(policy))
      RLD_BURST: fire = burst_end;
      RLD_BLOCK: fire = block_end;
      RLD_XACT:  fire = xact_end;
      default:   fire = 1'b0;
    endcase
  end
endmodule

// File: rtl/dag_lane.sv
module dag_lane
  import dag_pkg::*;
#(
  parameter int AW = 24
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          load,
  input  logic [AW-1:0] start,
  input  logic [1:0]    dir,
  input  logic [1:0]    rld,
  input  logic          step,
  input  logic          burst_end,
  input  logic          block_end,
  input  logic          xact_end,
  output logic [AW-1:0] addr
);
  logic [AW-1:0] saved_q;
  logic [AW-1:0] addr_q;
  logic [AW-1:0] stepped;
  logic          fire;

  dag_reload_sel u_sel (
    .policy    (rld),
    .burst_end (burst_end),
    .block_end (block_end),
    .xact_end  (xact_end),
    .fire      (fire)
  );

  always_comb begin
    case (dir_e'(dir))
      DIR_UP:   stepped = addr_q + AW'(1);
      DIR_DOWN: stepped = addr_q - AW'(1);
      default:  stepped = addr_q;
    endcase
  end

  // priority: load, then reload, then step
  always_ff @(posedge clk) begin
    if (rst) begin
      saved_q <= '0;
      addr_q  <= '0;
    end else if (load) begin
      saved_q <= start;
      addr_q  <= start;
    end else if (fire) begin
      addr_q  <= saved_q;
    end else if (step) begin
      addr_q  <= stepped;
    end
  end

  assign addr = addr_q;
endmodule

// File: rtl/dma_addr_gen.sv
module dma_addr_gen
  import dag_pkg::*;
#(
  parameter int ADDR_W = 24
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              src_load,
  input  logic [ADDR_W-1:0] src_start,
  input  logic [1:0]        src_dir,
  input  logic [1:0]        src_rld,
  input  logic              src_step,
  input  logic              dst_load,
  input  logic [ADDR_W-1:0] dst_start,
  input  logic [1:0]        dst_dir,
  input  logic [1:0]        dst_rld,
  input  logic              dst_step,
  input  logic              burst_end,
  input  logic              block_end,
  input  logic              xact_end,
  output logic [ADDR_W-1:0] src_addr,
  output logic [ADDR_W-1:0] dst_addr
);
  logic [NUM_LANES-1:0]             ld;
  logic [NUM_LANES-1:0]             stp;
  logic [NUM_LANES-1:0][ADDR_W-1:0] st;
  logic [NUM_LANES-1:0][ADDR_W-1:0] ad;
  logic [NUM_LANES-1:0][1:0]        dr;
  logic [NUM_LANES-1:0][1:0]        rl;

  // lane 0 = source, lane 1 = destination
  assign ld  = {dst_load, src_load};
  assign stp = {dst_step, src_step};
  assign st  = {dst_start, src_start};
  assign dr  = {dst_dir, src_dir};
  assign rl  = {dst_rld, src_rld};

  for (genvar g = 0; g < NUM_LANES; g++) begin : g_lane
    dag_lane #(.AW(ADDR_W)) u_lane (
      .clk       (clk),
      .rst       (rst),
      .load      (ld[g]),
      .start     (st[g]),
      .dir       (dr[g]),
      .rld       (rl[g]),
      .step      (stp[g]),
      .burst_end (burst_end),
      .block_end (block_end),
      .xact_end  (xact_end),
      .addr      (ad[g])
    );
  end

  assign src_addr = ad[0];
  assign dst_addr = ad[1];
endmodule

// File: rtl/dag_check.sv
module dag_check #(
  parameter int AW = 24
) (
  input logic          clk,
  input logic          rst,
  input logic          src_load,
  input logic [AW-1:0] src_start,
  input logic [1:0]    src_dir,
  input logic [1:0]    src_rld,
  input logic          src_step,
  input logic          dst_load,
  input logic [AW-1:0] dst_start,
  input logic [1:0]    dst_dir,
  input logic [1:0]    dst_rld,
  input logic          dst_step,
  input logic          burst_end,
  input logic          block_end,
  input logic          xact_end,
  input logic [AW-1:0] src_addr,
  input logic [AW-1:0] dst_addr
);
  logic [AW-1:0] sh_src, sh_dst;
  logic          s_ev, d_ev;

  always_ff @(posedge clk) begin
    if (rst) begin
      sh_src <= '0;
      sh_dst <= '0;
    end else begin
      if (src_load) sh_src <= src_start;
      if (dst_load) sh_dst <= dst_start;
    end
  end

  assign s_ev = (src_rld == 2'd1 && burst_end) || (src_rld == 2'd2 && block_end) ||
                (src_rld == 2'd3 && xact_end);
  assign d_ev = (dst_rld == 2'd1 && burst_end) || (dst_rld == 2'd2 && block_end) ||
                (dst_rld == 2'd3 && xact_end);

  p_load_r2: assert property (@(posedge clk) disable iff (rst)
    src_load |=> src_addr == $past(src_start));
  p_dst_load_r10: assert property (@(posedge clk) disable iff (rst)
    dst_load |=> dst_addr == $past(dst_start));
  // reload regardless of the step strobe: covers R7 and R9
  p_reload_r9: assert property (@(posedge clk) disable iff (rst)
    (!src_load && s_ev) |=> src_addr == sh_src);
  p_dst_reload_r7: assert property (@(posedge clk) disable iff (rst)
    (!dst_load && d_ev) |=> dst_addr == sh_dst);
  p_up_r3: assert property (@(posedge clk) disable iff (rst)
    (!src_load && !s_ev && src_step && src_dir == 2'd1) |=> src_addr == AW'($past(src_addr) + AW'(1)));
  p_down_r4: assert property (@(posedge clk) disable iff (rst)
    (!dst_load && !d_ev && dst_step && dst_dir == 2'd2) |=> dst_addr == AW'($past(dst_addr) - AW'(1)));
  p_fixed_r5: assert property (@(posedge clk) disable iff (rst)
    (!src_load && !s_ev && (src_dir == 2'd0 || src_dir == 2'd3)) |=> $stable(src_addr));
  // no selected event (includes never policy, R8) and no step
  p_hold_r6: assert property (@(posedge clk) disable iff (rst)
    (!dst_load && !d_ev && !dst_step) |=> $stable(dst_addr));
endmodule

bind dma_addr_gen dag_check #(.AW(ADDR_W)) u_chk (.*);

// File: tb/sim_dma_addr_gen.sv
module sim_dma_addr_gen;
  localparam int AW = 24;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic          rst;
  logic          src_load, dst_load, src_step, dst_step;
  logic [AW-1:0] src_start, dst_start;
  logic [1:0]    src_dir, src_rld, dst_dir, dst_rld;
  logic          burst_end, block_end, xact_end;
  logic [AW-1:0] src_addr, dst_addr;

  dma_addr_gen #(.ADDR_W(AW)) u0 (.*);

  typedef struct {
    string         tag;
    logic [AW-1:0] s;
    logic [AW-1:0] d;
  } exp_t;

  exp_t q[$];
  int n_run = 0;
  int n_fail = 0;

  logic [AW-1:0] m_src = '0, m_dst = '0, sv_src = '0, sv_dst = '0;
  logic [1:0]    c_sdir = 2'd0, c_srld = 2'd0, c_ddir = 2'd0, c_drld = 2'd0;

  function automatic logic [AW-1:0] model_next(input logic [AW-1:0] cur, sv, st,
      input logic ld, stp, input logic [1:0] dir, rld, input logic bu, bl, xa);
    logic ev;
    ev = (rld == 2'd1 && bu) || (rld == 2'd2 && bl) || (rld == 2'd3 && xa);
    if (ld) return st;
    if (ev) return sv;
    if (stp && dir == 2'd1) return cur + AW'(1);
    if (stp && dir == 2'd2) return cur - AW'(1);
    return cur;
  endfunction

  task automatic cyc(input string tag, input logic sl, input logic [AW-1:0] ss, input logic sst,
      input logic dl, input logic [AW-1:0] ds, input logic dstp,
      input logic bu, input logic bl, input logic xa);
    exp_t e;
    @(negedge clk);
    src_load = sl; src_start = ss; src_step = sst; src_dir = c_sdir; src_rld = c_srld;
    dst_load = dl; dst_start = ds; dst_step = dstp; dst_dir = c_ddir; dst_rld = c_drld;
    burst_end = bu; block_end = bl; xact_end = xa;
    e.tag = tag;
    e.s = model_next(m_src, sv_src, ss, sl, sst, c_sdir, c_srld, bu, bl, xa);
    e.d = model_next(m_dst, sv_dst, ds, dl, dstp, c_ddir, c_drld, bu, bl, xa);
    if (sl) sv_src = ss;
    if (dl) sv_dst = ds;
    m_src = e.s;
    m_dst = e.d;
    @(posedge clk);
    #1 q.push_back(e);
  endtask

  task automatic steps(input string tag, input int n, input logic s, input logic d);
    for (int i = 0; i < n; i++) cyc(tag, 0, '0, s, 0, '0, d, 0, 0, 0);
  endtask

  // monitor / scoreboard
  always @(negedge clk) begin
    if (q.size() > 0) begin
      exp_t e;
      e = q.pop_front();
      n_run++;
      if (src_addr !== e.s || dst_addr !== e.d) begin
        n_fail++;
        $display("FAIL %s: src=%h dst=%h expected src=%h dst=%h",
                 e.tag, src_addr, dst_addr, e.s, e.d);
      end
    end
  end

  initial begin
    #(200000 * 10);
    n_fail++;
    $display("FAIL watchdog: run did not complete, expected completion");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    rst = 1'b1;
    src_load = 0; dst_load = 0; src_step = 0; dst_step = 0;
    src_start = '0; dst_start = '0; src_dir = 0; src_rld = 0; dst_dir = 0; dst_rld = 0;
    burst_end = 0; block_end = 0; xact_end = 0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    n_run++;
    if (src_addr !== '0 || dst_addr !== '0) begin
      n_fail++;
      $display("FAIL R1 reset: src=%h dst=%h expected src=000000 dst=000000", src_addr, dst_addr);
    end
    rst = 1'b0;

    // R2 R11: loads, then count up and down
    c_sdir = 2'd1; c_ddir = 2'd2;
    cyc("R2 R11 load both", 1, 24'h000010, 0, 1, 24'h000100, 0, 0, 0, 0);
    steps("R3 R4 step both", 3, 1, 1);
    steps("R11 src only", 2, 1, 0);
    steps("R11 dst only", 1, 0, 1);
    steps("R6 idle hold", 2, 0, 0);

    // R3 R4 wrap
    cyc("R3 R4 wrap load", 1, 24'hFFFFFE, 0, 1, 24'h000001, 0, 0, 0, 0);
    steps("R3 R4 wrap step", 3, 1, 1);

    // R5 fixed and reserved direction
    c_sdir = 2'd0; c_ddir = 2'd3;
    steps("R5 fixed step", 2, 1, 1);

    // R7 selected events
    c_sdir = 2'd1; c_srld = 2'd1; c_ddir = 2'd2; c_drld = 2'd2;
    cyc("R7 load", 1, 24'h000200, 0, 1, 24'h000300, 0, 0, 0, 0);
    steps("R7 advance", 2, 1, 1);
    cyc("R7 block_end", 0, '0, 0, 0, '0, 0, 0, 1, 0);
    steps("R7 advance", 2, 1, 1);
    cyc("R7 burst_end", 0, '0, 0, 0, '0, 0, 1, 0, 0);
    cyc("R7 xact_end unselected", 0, '0, 0, 0, '0, 0, 0, 0, 1);
    c_srld = 2'd3; c_drld = 2'd3;
    steps("R7 advance", 2, 1, 1);
    cyc("R7 xact_end", 0, '0, 0, 0, '0, 0, 0, 0, 1);

    // R8 never
    c_srld = 2'd0; c_drld = 2'd0;
    steps("R8 advance", 2, 1, 1);
    cyc("R8 burst_end", 0, '0, 0, 0, '0, 0, 1, 0, 0);
    cyc("R8 block_end", 0, '0, 0, 0, '0, 0, 0, 1, 0);
    cyc("R8 xact_end", 0, '0, 0, 0, '0, 0, 0, 0, 1);
    cyc("R8 all events", 0, '0, 0, 0, '0, 0, 1, 1, 1);

    // R9 reload beats step
    c_srld = 2'd1; c_drld = 2'd1;
    steps("R9 advance", 3, 1, 1);
    cyc("R9 step with burst_end", 0, '0, 1, 0, '0, 1, 1, 0, 0);

    // R10 load beats reload and step
    steps("R10 advance", 2, 1, 1);
    cyc("R10 load with step and event", 1, 24'h00ABCD, 1, 1, 24'h123456, 1, 1, 0, 0);
    steps("R10 after load", 2, 1, 1);
    cyc("R10 reload to new start", 0, '0, 0, 0, '0, 0, 1, 0, 0);

    repeat (3) @(negedge clk);
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule